// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a set of peripheral interrupt request lines and sorts each of them into one of three tiers before they reach a processor. A request that software has put in the fast class drives a dedicated fast-interrupt output. It does not use the vector lookup. All other enabled requests drive a normal-interrupt output. For the normal requests, a bank of programmable vector slots, each holding a source number and a handler address, provides the vector. Slot order fixes priority, and lower slot numbers win. A request whose source is in no enabled slot is non-vectored and sits in the lowest tier.

Software works with the block through a simple word-addressed register bus. When it reads the vector register, it gets the handler address of the winning slot, or a shared default address if no slot matches. That read also marks a service level. While the level is marked, only strictly higher-priority slots can raise the normal output. Software ends the service by writing any value to the vector register. A software-request register is ORed with the hardware lines, so software can raise a request itself. Status words show the raw, masked, fast-class and normal-class request vectors.

Top module: `vic_top`

## Requirements
- R1: `fiq_o` is the OR of all sources that are enabled and have their class bit set to 1 (fast). It is registered, so it follows the request one clock later. Fast-class sources never affect `irq_o`.
- R2: The fast status word (word address 0x02) shows, bit per source, the sources that are requesting, enabled and in the fast class.
- R3: The enable mask (word 0x04) gates each source before classification. A source whose enable bit is 0 shows only in the raw status (word 0x00). It is absent from the masked (0x01), fast (0x02) and normal (0x03) status words and from both outputs.
- R4: While no service level is marked, `irq_o` is the OR of the enabled sources whose class bit (word 0x05) is 0, registered one clock later.
- R5: A read of the vector register (word 0x08) returns the handler address (word 0x80+n) of the lowest-numbered enabled slot whose source is requesting, enabled and in the normal class. Slot 0 has the highest priority, whatever the source numbers. Fast-class sources never match a slot.
- R6: Slot control words (0x40+n) hold the source number in bits 4:0 and the slot enable in bit 5. Any source may be placed in any slot, and a slot with enable 0 never matches.
- R7: When no slot matches, a vector read returns the default address register (word 0x09). After reset, a vector read returns 0.
- R8: A vector read marks the winning slot as the service level, or marks the level below all slots if the default address was returned. From the clock after the read, `irq_o` is raised only by matching slots numbered below that level. Non-vectored requests cannot raise it in that time. Any write to word 0x08 removes the mark.
- R9: A write to word 0x06 ORs its data into the software-request register. A write to word 0x07 clears the bits set in its data. Software requests appear in the raw status and are handled like hardware requests.
- R10: After reset, all registers are 0, both outputs are low, and no service level is marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src_i | input | NUM_SRC | Peripheral request lines, level sensitive, synchronous to clk |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe; a read of word 0x08 has a side effect |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as bus_rd_i |
| fiq_o | output | 1 | Fast interrupt to the processor |
| irq_o | output | 1 | Normal interrupt to the processor |

## Verification
The bench builds the block with its default parameters: 32 sources and 16 slots. Source numbers up to 31 are therefore reachable through the 5-bit slot field, and the priority scan covers the full slot range. The bench uses slots whose priority order is the reverse of their source-number order, so that slot priority can be told apart from source order. It also uses a disabled slot, a fast-class source assigned to a slot, and an unassigned source. For the service level it checks both cases: a level marked by a vectored read, which a higher slot can pre-empt, and a level marked by a default read, which blocks non-vectored requests.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_RAW      = 8'h00;
  localparam logic [ADDR_W-1:0] A_MASKED   = 8'h01;
  localparam logic [ADDR_W-1:0] A_FAST     = 8'h02;
  localparam logic [ADDR_W-1:0] A_NORM     = 8'h03;
  localparam logic [ADDR_W-1:0] A_ENABLE   = 8'h04;
  localparam logic [ADDR_W-1:0] A_CLASS    = 8'h05;
  localparam logic [ADDR_W-1:0] A_SOFT_SET = 8'h06;
  localparam logic [ADDR_W-1:0] A_SOFT_CLR = 8'h07;
  localparam logic [ADDR_W-1:0] A_VECTOR   = 8'h08;
  localparam logic [ADDR_W-1:0] A_DEFAULT  = 8'h09;
  localparam logic [ADDR_W-1:0] A_SLOT_CTL = 8'h40;
  localparam logic [ADDR_W-1:0] A_SLOT_VEC = 8'h80;

  localparam int unsigned SLOT_EN_BIT = 5;
endpackage

// File: rtl/vic_req_front.sv
module vic_req_front #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] hw_req_i,
  input  logic [NUM_SRC-1:0] soft_req_i,
  input  logic [NUM_SRC-1:0] enable_i,
  input  logic [NUM_SRC-1:0] fast_sel_i,
  output logic [NUM_SRC-1:0] raw_o,
  output logic [NUM_SRC-1:0] masked_o,
  output logic [NUM_SRC-1:0] fast_o,
  output logic [NUM_SRC-1:0] norm_o
);
  always_comb begin
    raw_o    = hw_req_i | soft_req_i;
    masked_o = raw_o & enable_i;
    fast_o   = masked_o & fast_sel_i;
    norm_o   = masked_o & ~fast_sel_i;
  end
endmodule

// File: rtl/vic_slot_match.sv
module vic_slot_match #(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_SLOT = 16,
  localparam int unsigned SRC_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]              norm_req_i,
  input  logic [NUM_SLOT-1:0]             slot_en_i,
  input  logic [NUM_SLOT-1:0][SRC_W-1:0]  slot_src_i,
  output logic [NUM_SLOT-1:0]             slot_hit_o
);
  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    assign slot_hit_o[g] = slot_en_i[g] & norm_req_i[slot_src_i[g]];
  end
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int unsigned N   = 16,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_SLOT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               fiq_o,
  output logic               irq_o
);
  localparam int unsigned SRC_W  = $clog2(NUM_SRC);
  localparam int unsigned IDX_W  = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1;
  localparam int unsigned LVL_W  = $clog2(NUM_SLOT + 1);
  localparam int unsigned SLOT_AW = $clog2(NUM_SLOT);

  logic [NUM_SRC-1:0]             en_q, cls_q, soft_q;
  logic [DATA_W-1:0]              dflt_q;
  logic [NUM_SLOT-1:0]            slot_en_q;
  logic [NUM_SLOT-1:0][SRC_W-1:0] slot_src_q;
  logic [NUM_SLOT-1:0][DATA_W-1:0] slot_vec_q;
  logic                           svc_act_q;
  logic [LVL_W-1:0]               svc_lvl_q;
  logic                           fiq_q, irq_q;

  logic [NUM_SRC-1:0]  raw_vec, masked_vec, fast_vec, norm_vec;
  logic [NUM_SLOT-1:0] slot_hit, lvl_mask;
  logic                hit_any;
  logic [IDX_W-1:0]    hit_idx;

  vic_req_front #(.NUM_SRC(NUM_SRC)) front_i (
    .hw_req_i  (irq_src_i),
    .soft_req_i(soft_q),
    .enable_i  (en_q),
    .fast_sel_i(cls_q),
    .raw_o     (raw_vec),
    .masked_o  (masked_vec),
    .fast_o    (fast_vec),
    .norm_o    (norm_vec)
  );

  vic_slot_match #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) match_i (
    .norm_req_i(norm_vec),
    .slot_en_i (slot_en_q),
    .slot_src_i(slot_src_q),
    .slot_hit_o(slot_hit)
  );

  vic_prio_enc #(.N(NUM_SLOT)) prio_i (
    .req_i(slot_hit),
    .any_o(hit_any),
    .idx_o(hit_idx)
  );

  // slots strictly above the marked level in priority
  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_lvl
    assign lvl_mask[g] = (LVL_W'(g) < svc_lvl_q);
  end

  // address decode
  logic wr_slot_ctl, wr_slot_vec, rd_vec, wr_vec;
  logic [SLOT_AW-1:0] slot_sel;
  logic slot_in_range;
  assign slot_sel      = bus_addr_i[SLOT_AW-1:0];
  assign slot_in_range = ({1'b0, bus_addr_i[5:0]} < 7'(NUM_SLOT));
  assign wr_slot_ctl = bus_wr_i && (bus_addr_i[7:6] == A_SLOT_CTL[7:6]) && slot_in_range;
  assign wr_slot_vec = bus_wr_i && (bus_addr_i[7:6] == A_SLOT_VEC[7:6]) && slot_in_range;
  assign rd_vec      = bus_rd_i && (bus_addr_i == A_VECTOR);
  assign wr_vec      = bus_wr_i && (bus_addr_i == A_VECTOR);

  logic [DATA_W-1:0] vec_addr;
  assign vec_addr = hit_any ? slot_vec_q[hit_idx] : dflt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q       <= '0;
      cls_q      <= '0;
      soft_q     <= '0;
      dflt_q     <= '0;
      slot_en_q  <= '0;
      slot_src_q <= '0;
      slot_vec_q <= '0;
    end else if (bus_wr_i) begin
      case (bus_addr_i)
        A_ENABLE:   en_q   <= bus_wdata_i[NUM_SRC-1:0];
        A_CLASS:    cls_q  <= bus_wdata_i[NUM_SRC-1:0];
        A_SOFT_SET: soft_q <= soft_q | bus_wdata_i[NUM_SRC-1:0];
        A_SOFT_CLR: soft_q <= soft_q & ~bus_wdata_i[NUM_SRC-1:0];
        A_DEFAULT:  dflt_q <= bus_wdata_i;
        default: ;
      endcase
      if (wr_slot_ctl) begin
        slot_en_q[slot_sel]  <= bus_wdata_i[SLOT_EN_BIT];
        slot_src_q[slot_sel] <= bus_wdata_i[SRC_W-1:0];
      end
      if (wr_slot_vec) slot_vec_q[slot_sel] <= bus_wdata_i;
    end
  end

  // service level: vector read marks, vector write releases
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_act_q <= 1'b0;
      svc_lvl_q <= '0;
    end else if (wr_vec) begin
      svc_act_q <= 1'b0;
      svc_lvl_q <= '0;
    end else if (rd_vec) begin
      svc_act_q <= 1'b1;
      svc_lvl_q <= hit_any ? LVL_W'(hit_idx) : LVL_W'(NUM_SLOT);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fiq_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      fiq_q <= |fast_vec;
      irq_q <= svc_act_q ? |(slot_hit & lvl_mask) : |norm_vec;
    end
  end

  assign fiq_o = fiq_q;
  assign irq_o = irq_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      unique casez (bus_addr_i)
        A_RAW:      bus_rdata_o = DATA_W'(raw_vec);
        A_MASKED:   bus_rdata_o = DATA_W'(masked_vec);
        A_FAST:     bus_rdata_o = DATA_W'(fast_vec);
        A_NORM:     bus_rdata_o = DATA_W'(norm_vec);
        A_ENABLE:   bus_rdata_o = DATA_W'(en_q);
        A_CLASS:    bus_rdata_o = DATA_W'(cls_q);
        A_SOFT_SET: bus_rdata_o = DATA_W'(soft_q);
        A_VECTOR:   bus_rdata_o = vec_addr;
        A_DEFAULT:  bus_rdata_o = dflt_q;
        8'b01??????: if (slot_in_range) bus_rdata_o =
                       DATA_W'({slot_en_q[slot_sel], 5'(slot_src_q[slot_sel])});
        8'b10??????: if (slot_in_range) bus_rdata_o = slot_vec_q[slot_sel];
        default: ;
      endcase
    end
  end

  // R1: fast output follows the fast-class OR one clock later
  p_fiq_tracks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fiq_o == $past(|fast_vec)));

  // R4: with no service level marked, normal output tracks normal requests
  p_irq_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !svc_act_q |=> (irq_o == $past(|norm_vec)));

  // R8: during service, no slot hit means no normal interrupt
  p_irq_in_service_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_act_q && !(|slot_hit)) |=> !irq_o);

  // R8: a vector read marks a service level
  p_vec_read_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && !wr_vec) |=> svc_act_q);

  // R7: no slot hit returns the default address
  p_vec_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && !(|slot_hit)) |-> (bus_rdata_o == dflt_q));

  // R9: cleared software requests are gone after the write
  p_soft_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == A_SOFT_CLR) |=>
      ((soft_q & $past(bus_wdata_i[NUM_SRC-1:0])) == '0));
endmodule

// File: tb/vic_top_tb_top.sv
module vic_top_tb_top;
  import vic_pkg::*;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fiq, irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  vic_top dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .fiq_o(fiq), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #(CLK_P/4);
    d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R10 fiq", {31'b0, fiq}, 0);
    chk("R10 irq", {31'b0, irq}, 0);
    rd(A_RAW, d);    chk("R10 raw", d, 0);
    rd(A_ENABLE, d); chk("R10 enable", d, 0);
    rd(A_VECTOR, d); chk("R7 reset vector", d, 0);
    wr(A_VECTOR, 0);
  endtask

  task automatic t_fast;
    logic [31:0] d;
    wr(A_ENABLE, 32'hFFFF_FFFF);
    wr(A_CLASS, 32'h0000_0008);
    irq_src = 32'h0000_0008;
    step(2);
    chk("R1 fiq set", {31'b0, fiq}, 1);
    chk("R1 irq untouched", {31'b0, irq}, 0);
    rd(A_FAST, d); chk("R2 fast status", d, 32'h8);
    irq_src = 32'h0000_0088;
    step(2);
    rd(A_FAST, d); chk("R2 fast status only fast", d, 32'h8);
    rd(A_NORM, d); chk("R4 normal status", d, 32'h80);
    chk("R4 irq set", {31'b0, irq}, 1);
    irq_src = 0;
    step(2);
    chk("R1 fiq clear", {31'b0, fiq}, 0);
    chk("R4 irq clear", {31'b0, irq}, 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(A_ENABLE, 32'hFFFF_FFDF);
    wr(A_CLASS, 32'h0000_0020);
    irq_src = 32'h0000_0020;
    step(2);
    chk("R3 fiq masked", {31'b0, fiq}, 0);
    rd(A_RAW, d);    chk("R3 raw", d, 32'h20);
    rd(A_MASKED, d); chk("R3 masked", d, 0);
    wr(A_CLASS, 0);
    step(2);
    chk("R3 irq masked", {31'b0, irq}, 0);
    irq_src = 0;
    wr(A_ENABLE, 32'hFFFF_FFFF);
  endtask

  task automatic t_vector;
    logic [31:0] d;
    wr(A_DEFAULT, 32'hD000_0000);
    wr(A_SLOT_CTL + 2, 32'h20 | 9);  wr(A_SLOT_VEC + 2, 32'hA000_0002);
    wr(A_SLOT_CTL + 7, 32'h20 | 4);  wr(A_SLOT_VEC + 7, 32'hA000_0007);
    wr(A_SLOT_CTL + 15, 32'h20 | 31); wr(A_SLOT_VEC + 15, 32'hA000_000F);
    irq_src = 32'h0000_0010;
    step(1);
    rd(A_VECTOR, d); chk("R5 single slot", d, 32'hA000_0007); wr(A_VECTOR, 0);
    irq_src = 32'h8000_0210;
    step(1);
    rd(A_VECTOR, d); chk("R5 slot order", d, 32'hA000_0002); wr(A_VECTOR, 0);
    irq_src = 32'h8000_0000;
    step(1);
    rd(A_VECTOR, d); chk("R6 source 31 slot 15", d, 32'hA000_000F); wr(A_VECTOR, 0);
    irq_src = 32'h0010_0000;
    step(1);
    rd(A_VECTOR, d); chk("R7 default", d, 32'hD000_0000); wr(A_VECTOR, 0);
    irq_src = 32'h0000_0200;
    wr(A_SLOT_CTL + 2, 9);
    rd(A_VECTOR, d); chk("R6 disabled slot", d, 32'hD000_0000); wr(A_VECTOR, 0);
    wr(A_SLOT_CTL + 2, 32'h20 | 9);
    wr(A_CLASS, 32'h0000_0200);
    rd(A_VECTOR, d); chk("R5 fast source skips slot", d, 32'hD000_0000); wr(A_VECTOR, 0);
    wr(A_CLASS, 0);
    irq_src = 0;
    step(2);
  endtask

  task automatic t_level;
    logic [31:0] d;
    irq_src = 32'h0000_0010;
    step(2);
    chk("R4 irq before read", {31'b0, irq}, 1);
    rd(A_VECTOR, d); chk("R8 read slot 7", d, 32'hA000_0007);
    step(2);
    chk("R8 same level held", {31'b0, irq}, 0);
    irq_src = 32'h0010_0010;
    step(2);
    chk("R8 non-vectored blocked", {31'b0, irq}, 0);
    irq_src = 32'h0010_0210;
    step(2);
    chk("R8 higher slot pre-empts", {31'b0, irq}, 1);
    irq_src = 32'h0010_0010;
    step(2);
    chk("R8 higher slot gone", {31'b0, irq}, 0);
    wr(A_VECTOR, 0);
    step(2);
    chk("R8 release", {31'b0, irq}, 1);
    irq_src = 32'h0010_0000;
    step(1);
    rd(A_VECTOR, d); chk("R7 default read", d, 32'hD000_0000);
    step(2);
    chk("R8 default level blocks", {31'b0, irq}, 0);
    irq_src = 32'h8010_0000;
    step(2);
    chk("R8 default level lets slots", {31'b0, irq}, 1);
    wr(A_VECTOR, 0);
    irq_src = 0;
    step(2);
  endtask

  task automatic t_soft;
    logic [31:0] d;
    wr(A_SOFT_SET, 32'h0000_1000);
    wr(A_SOFT_SET, 32'h0000_0040);
    step(1);
    rd(A_RAW, d); chk("R9 soft set", d, 32'h1040);
    chk("R9 soft irq", {31'b0, irq}, 1);
    wr(A_SOFT_CLR, 32'h0000_1000);
    rd(A_RAW, d); chk("R9 soft clear one", d, 32'h40);
    wr(A_SOFT_CLR, 32'hFFFF_FFFF);
    step(2);
    rd(A_RAW, d); chk("R9 soft clear all", d, 0);
    chk("R9 irq after clear", {31'b0, irq}, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset;
    t_fast;
    t_mask;
    t_vector;
    t_level;
    t_soft;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule